// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing side of a byte-addressed serial memory that answers on a two-wire clock/data bus. The bus lines are brought into the fast system clock domain through a short synchronizer, and bus events are detected on the synchronized copies. A transfer opens with a START. The master then sends a slave address byte and the block compares it against a fixed device code and an external chip-select pin. Two array-address bytes follow. Together with one address bit carried in the slave address byte, they form a 17-bit byte address.

After the address phase, a write transfer stores each further byte through a simple single-port memory interface. A read transfer, usually reached through a repeated START, sends bytes from that interface MSB first. The internal address counter advances after every byte moved and wraps inside the 17-bit space. The block pulls the data line low only through an open-drain enable. It never drives the line high.

The memory interface expects read data one system clock after the address. The array behind it is outside the block, and the bench provides a behavioural model of it.

Top module: `twi_mem_slave`

## Requirements
- R1: While reset is asserted and right after its release, `sdaOe` is 0, `memWe` is 0 and `memAddr` is 0.
- R2: A STOP (data rising while clock is high) returns the block to idle. Bytes clocked after it without a new START are not acknowledged.
- R3: A slave address byte sent MSB first with bits 7:4 = 1010, bit 3 = 0 and bit 2 equal to `csPin` is acknowledged: `sdaOe` is 1 while the clock is high in the ninth clock period.
- R4: A slave address byte that does not match leaves the data line released. Every later byte is ignored (no acknowledge, no `memWe`) until the next START.
- R5: Bit 1 of the slave address byte loads address bit 16. The first array-address byte loads bits 15:8 and the second loads bits 7:0.
- R6: In a write (bit 0 of the slave address byte = 0), every data byte after the two address bytes is acknowledged. It is written to `memAddr` with exactly one single-cycle `memWe` pulse.
- R7: In a read (bit 0 = 1), the byte at the current address is sent MSB first. `sdaOe` = 1 encodes a 0 bit. `sdaOe` changes only while the synchronized clock is low, except on START or STOP.
- R8: The address counter increments by one after each byte written or read and wraps from 0x1FFFF to 0x00000.
- R9: When the master answers a read byte with a high level (NACK), the block stops driving. Any further clocks read back all ones until a STOP or START.
- R10: A repeated START in mid-transfer releases the data line and restarts the slave address phase. This allows a random read.
- R11: The chip-select bit (slave address bit 2) is compared against the live level of `csPin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| csPin | input | 1 | Chip-select strap compared with slave address bit 2 |
| sdaOe | output | 1 | Pull the data line low when 1 |
| memAddr | output | 17 | Current memory byte address |
| memWe | output | 1 | One-cycle write strobe |
| memWdata | output | 8 | Byte to write |
| memRdata | input | 8 | Read data, valid one clock after `memAddr` |

## Verification
The hardest situations to reach are those where the counter and the bus phases interact: the counter wrap, and the release of the line after a master NACK. The wrap is reached by a write whose two address bytes and address bit select 0x1FFFF, followed by two data bytes. The byte after the NACK is checked by clocking one more byte with the data line released; an all-ones result shows the block is not driving. A current-address read after the wrapped write confirms that address bit 16 is reloaded from the new slave address byte while the low bits keep the counter value.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  localparam int ADDR_W = 17;
  localparam int BYTE_W = 8;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef struct packed {
    logic shiftIn;
    logic loadDev;
    logic loadHi;
    logic loadLo;
    logic writeMem;
    logic loadTx;
    logic shiftTx;
    logic sampleAck;
  } strobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_ACKDEV, ST_AHI, ST_ACKHI, ST_ALO, ST_ACKLO,
    ST_WDAT, ST_ACKW, ST_RDAT, ST_MACK, ST_IGNORE
  } state_t;
endpackage

// File: rtl/twi_bus_sync.sv
module twi_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclD <= sclPipe[STAGES-1];
      sdaD <= sdaPipe[STAGES-1];
    end
  end

  assign sclS = sclPipe[STAGES-1];
  assign sdaS = sdaPipe[STAGES-1];
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet = sclS & sclD & ~sdaD & sdaS;
endmodule

// File: rtl/twi_mem_dpath.sv
module twi_mem_dpath
  import twi_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaS,
  input  logic              csPin,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] memRdata,
  output logic              devMatch,
  output logic              rwBit,
  output logic              masterNack,
  output logic              txBit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata
);
  localparam int HI_LSB = BYTE_W;
  localparam int TOP_BIT = ADDR_W - 1;

  logic [BYTE_W-1:0] rxShift, txShift;
  logic [ADDR_W-1:0] addrCnt;
  logic rwReg, nackReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      addrCnt <= '0;
      rwReg <= 1'b0;
      nackReg <= 1'b1;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaS};
      if (stb.loadDev) begin
        addrCnt[TOP_BIT] <= rxShift[1];
        rwReg <= rxShift[0];
      end
      if (stb.loadHi) addrCnt[HI_LSB +: BYTE_W] <= rxShift;
      if (stb.loadLo) addrCnt[BYTE_W-1:0] <= rxShift;
      if (stb.writeMem) addrCnt <= addrCnt + 1'b1;
      if (stb.loadTx) begin
        txShift <= memRdata;
        addrCnt <= addrCnt + 1'b1;
      end
      if (stb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
      if (stb.sampleAck) nackReg <= sdaS;
    end
  end

  assign devMatch = (rxShift[7:4] == DEV_CODE) && !rxShift[3] && (rxShift[2] == csPin);
  assign rwBit = rwReg;
  assign masterNack = nackReg;
  assign txBit = txShift[BYTE_W-1];
  assign memAddr = addrCnt;
  assign memWdata = rxShift;
endmodule

// File: rtl/twi_mem_ctrl.sv
module twi_mem_ctrl
  import twi_mem_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    startDet,
  input  logic    stopDet,
  input  logic    devMatch,
  input  logic    rwBit,
  input  logic    masterNack,
  input  logic    txBit,
  output strobe_t stb,
  output logic    sdaOe,
  output logic    memWe
);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

  state_t state, nxt;
  logic [CNT_W-1:0] bitCnt, cntNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state <= nxt;
      bitCnt <= cntNxt;
    end
  end

  always_comb begin
    nxt = state;
    cntNxt = bitCnt;
    stb = '0;
    if (startDet) begin
      nxt = ST_DEV;
      cntNxt = '0;
    end else if (stopDet) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            cntNxt = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == LAST_RX) begin
            cntNxt = '0;
            if (state == ST_DEV) begin
              if (devMatch) begin
                stb.loadDev = 1'b1;
                nxt = ST_ACKDEV;
              end else begin
                nxt = ST_IGNORE;
              end
            end else if (state == ST_AHI) begin
              stb.loadHi = 1'b1;
              nxt = ST_ACKHI;
            end else if (state == ST_ALO) begin
              stb.loadLo = 1'b1;
              nxt = ST_ACKLO;
            end else begin
              stb.writeMem = 1'b1;
              nxt = ST_ACKW;
            end
          end
        end
        ST_ACKDEV: if (sclFall) begin
          if (rwBit) begin
            stb.loadTx = 1'b1;
            nxt = ST_RDAT;
          end else begin
            nxt = ST_AHI;
          end
        end
        ST_ACKHI: if (sclFall) nxt = ST_ALO;
        ST_ACKLO, ST_ACKW: if (sclFall) nxt = ST_WDAT;
        ST_RDAT: if (sclFall) begin
          if (bitCnt == LAST_TX) begin
            nxt = ST_MACK;
            cntNxt = '0;
          end else begin
            stb.shiftTx = 1'b1;
            cntNxt = bitCnt + 1'b1;
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            stb.sampleAck = 1'b1;
          end else if (sclFall) begin
            if (!masterNack) begin
              stb.loadTx = 1'b1;
              nxt = ST_RDAT;
            end else begin
              nxt = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_ACKDEV, ST_ACKHI, ST_ACKLO, ST_ACKW: sdaOe = 1'b1;
      ST_RDAT: sdaOe = ~txBit;
      default: sdaOe = 1'b0;
    endcase
  end

  assign memWe = stb.writeMem;
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              csPin,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [BYTE_W-1:0] memWdata,
  input  logic [BYTE_W-1:0] memRdata
);
  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic devMatch, rwBit, masterNack, txBit;
  strobe_t stb;

  twi_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  twi_mem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .devMatch(devMatch),
    .rwBit(rwBit), .masterNack(masterNack), .txBit(txBit),
    .stb(stb), .sdaOe(sdaOe), .memWe(memWe)
  );

  twi_mem_dpath u_dpath (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .csPin(csPin), .stb(stb),
    .memRdata(memRdata), .devMatch(devMatch), .rwBit(rwBit),
    .masterNack(masterNack), .txBit(txBit), .memAddr(memAddr),
    .memWdata(memWdata)
  );
endmodule

// File: rtl/twi_mem_checker.sv
module twi_mem_checker
  import twi_mem_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sclS,
  input logic              startDet,
  input logic              stopDet,
  input logic              sdaOe,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);
  assert_we_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> memAddr == ($past(memAddr) + ADDR_W'(1)));

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

  assert_start_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe);

  assert_low_phase_change_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !$past(startDet) && !$past(stopDet)) |-> !sclS);
endmodule

bind twi_mem_slave twi_mem_checker u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .startDet(startDet),
  .stopDet(stopDet), .sdaOe(sdaOe), .memWe(memWe), .memAddr(memAddr)
);

// File: tb/twi_mem_slave_bench.sv
module twi_mem_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic csPin = 1'b1;
  logic sdaOe, memWe;
  logic [16:0] memAddr;
  logic [7:0] memWdata, memRdata;
  logic busSda;
  logic [7:0] memModel [int];
  int nChecks = 0;
  int nFail = 0;
  int weCount = 0;
  logic done = 1'b0;

  assign busSda = mSda & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_mem_slave u_twi_mem_slave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda), .csPin(csPin),
    .sdaOe(sdaOe), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  function automatic logic [7:0] rdMem(input int a);
    if (memModel.exists(a)) return memModel[a];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    memRdata <= rdMem(int'(memAddr));
    if (memWe) begin
      memModel[int'(memAddr)] = memWdata;
      weCount++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; tick(HALF);
    mScl = 1'b1; tick(HALF);
    mSda = 1'b0; tick(HALF);
    mScl = 1'b0; tick(4);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(HALF);
    mScl = 1'b1; tick(HALF);
    mSda = 1'b1; tick(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(HALF);
      mScl = 1'b1; tick(HALF);
      mScl = 1'b0; tick(4);
    end
    mSda = 1'b1; tick(HALF);
    mScl = 1'b1; tick(HALF/2);
    acked = (busSda == 1'b0);
    tick(HALF/2);
    mScl = 1'b0; tick(4);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      mScl = 1'b1; tick(HALF/2);
      b[i] = busSda;
      tick(HALF/2);
      mScl = 1'b0; tick(4);
    end
    mSda = nack; tick(HALF);
    mScl = 1'b1; tick(HALF);
    mScl = 1'b0; tick(4);
    mSda = 1'b1;
  endtask

  function automatic logic [7:0] devByte(input logic cs, input logic a16, input logic rd);
    return {4'b1010, 1'b0, cs, a16, rd};
  endfunction

  task automatic testReset();
    check("R1 sdaOe in reset", sdaOe, 0);
    check("R1 memWe in reset", memWe, 0);
    rstN = 1'b1; tick(3);
    check("R1 sdaOe after reset", sdaOe, 0);
    check("R1 memAddr after reset", memAddr, 0);
  endtask

  task automatic testWrite();
    logic ack; int w0;
    w0 = weCount;
    busStart();
    sendByte(devByte(1'b1, 1'b1, 1'b0), ack); check("R3 dev ack", ack, 1);
    sendByte(8'h23, ack); check("R5 hi ack", ack, 1);
    sendByte(8'h45, ack); check("R5 lo ack", ack, 1);
    sendByte(8'hA5, ack); check("R6 data0 ack", ack, 1);
    sendByte(8'h3C, ack); check("R6 data1 ack", ack, 1);
    busStop();
    check("R5 R6 byte at 12345", rdMem(32'h12345), 8'hA5);
    check("R8 byte at 12346", rdMem(32'h12346), 8'h3C);
    check("R6 write pulses", weCount - w0, 2);
  endtask

  task automatic testRandomRead();
    logic ack; logic [7:0] b;
    memModel[32'hF0] = 8'h11; memModel[32'hF1] = 8'h22; memModel[32'hF2] = 8'h3B;
    busStart();
    sendByte(devByte(1'b1, 1'b0, 1'b0), ack);
    sendByte(8'h00, ack);
    sendByte(8'hF0, ack); check("R5 lo ack before restart", ack, 1);
    busStart();
    sendByte(devByte(1'b1, 1'b0, 1'b1), ack); check("R10 read dev ack", ack, 1);
    recvByte(1'b0, b); check("R7 R10 read byte0", b, 8'h11);
    recvByte(1'b0, b); check("R8 read byte1", b, 8'h22);
    recvByte(1'b1, b); check("R8 read byte2", b, 8'h3B);
    recvByte(1'b1, b); check("R9 released after nack", b, 8'hFF);
    check("R9 sdaOe low after nack", sdaOe, 0);
    busStop();
  endtask

  task automatic testMismatch();
    logic ack; int w0;
    w0 = weCount;
    busStart();
    sendByte(8'hB0, ack); check("R4 bad type nack", ack, 0);
    sendByte(8'h00, ack); check("R4 later byte ignored", ack, 0);
    sendByte(8'h77, ack); check("R4 later byte ignored 2", ack, 0);
    busStop();
    check("R4 no writes", weCount - w0, 0);
    busStart();
    sendByte(devByte(1'b0, 1'b0, 1'b0), ack); check("R11 cs mismatch nack", ack, 0);
    busStop();
    csPin = 1'b0;
    busStart();
    sendByte(devByte(1'b0, 1'b0, 1'b0), ack); check("R11 cs match low", ack, 1);
    busStop();
    csPin = 1'b1;
  endtask

  task automatic testWrap();
    logic ack; logic [7:0] b;
    busStart();
    sendByte(devByte(1'b1, 1'b1, 1'b0), ack);
    sendByte(8'hFF, ack);
    sendByte(8'hFF, ack);
    sendByte(8'h5E, ack);
    sendByte(8'h6F, ack); check("R8 ack after wrap", ack, 1);
    busStop();
    check("R8 byte at 1FFFF", rdMem(32'h1FFFF), 8'h5E);
    check("R8 byte at 00000", rdMem(0), 8'h6F);
    memModel[1] = 8'h9C;
    busStart();
    sendByte(devByte(1'b1, 1'b0, 1'b1), ack);
    recvByte(1'b1, b); check("R5 current address read", b, 8'h9C);
    busStop();
  endtask

  task automatic testStopIdle();
    logic ack;
    busStart();
    sendByte(devByte(1'b1, 1'b0, 1'b0), ack); check("R2 dev ack before stop", ack, 1);
    busStop();
    sendByte(devByte(1'b1, 1'b0, 1'b0), ack); check("R2 no ack without start", ack, 0);
    busStart();
    sendByte(devByte(1'b1, 1'b0, 1'b0), ack); check("R2 ack after new start", ack, 1);
    busStop();
  endtask

  initial begin
    tick(5);
    testReset();
    testWrite();
    testRandomRead();
    testMismatch();
    testWrap();
    testStopIdle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule